// File: doc/BRIEF.md
# Latching Parity Transceiver

This block joins two 9-bit buses, A and B. Each bus carries eight data bits and one parity bit. Each side of the block has its own level-sensitive holding stage. While its enable is high, the stage passes the live word through. While its enable is low, the stage keeps the word it last captured. Two active-low output enables choose a direction. In the A-to-B direction, the A-side stage drives the B pads. In the B-to-A direction, the B-side stage drives the A pads.

The outgoing parity bit is set by the mode input. In generate mode, the block replaces it with parity computed over the eight stage data bits, in even or odd sense. In pass mode, the block forwards the incoming parity bit unchanged. Each side continuously checks its own stage contents and reports a mismatch on an active-low error flag. When a side is driven by the block, its stage sees the driven word, so the block also checks its own output.

Each pad is modelled as three separate signals: an input, an output and an output enable. Holding stages are built from clocked registers. The stage view is combinational from the live input while the enable is high, and the register captures that view on each clock edge. Reset is synchronous and active low.

Top module: `ptx_top`

## Requirements
- R1: While a side's stage enable is high, that side's stage view equals the live word on its input, both for driving the opposite bus and for checking.
- R2: While a side's stage enable is low, its stage view is the word captured at the last clock edge at which the enable was high. A later change on the input pad has no effect on the driven output.
- R3: When drv_b_n=0 and drv_a_n=1, b_oe=1 and the B outputs carry the A-side stage word. When drv_a_n=0 and drv_b_n=1, a_oe=1 and the A outputs carry the B-side stage word. When both enables are 1, neither side is driven.
- R4: When drv_a_n=0 and drv_b_n=0, neither side is driven and both_en_flag=1. In every other case both_en_flag=0.
- R5: Generated parity is the XOR of the eight data bits when odd_sel=0 (even parity), and the inverse of that XOR when odd_sel=1 (odd parity).
- R6: With fwd_mode=0 (generate mode), the driven parity output is the parity generated from the source stage data.
- R7: With fwd_mode=1 (pass mode), the driven parity output is the source stage parity bit, unchanged.
- R8: A side's error flag (a_err_n or b_err_n) is 0 exactly when parity generated from that side's stage data differs from that side's stage parity bit. This holds in both modes.
- R9: A driven side's stage takes its input from the driven word instead of the pad. With its enable high, its error flag therefore checks the block's own output, and that flag never shows an error in generate mode.
- R10: After reset, a stage that has not captured anything reports no error. Its held word is all-zero data, with a parity bit equal to odd_sel.
- R11: The data and parity outputs of a side that is not driven are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| a_dat_i | input | 8 | A-side data pad input |
| a_par_i | input | 1 | A-side parity pad input |
| b_dat_i | input | 8 | B-side data pad input |
| b_par_i | input | 1 | B-side parity pad input |
| lat_a_en | input | 1 | A-side stage enable (1 = transparent) |
| lat_b_en | input | 1 | B-side stage enable (1 = transparent) |
| drv_b_n | input | 1 | Drive B from the A-side stage, active low |
| drv_a_n | input | 1 | Drive A from the B-side stage, active low |
| fwd_mode | input | 1 | 1 = pass parity through, 0 = generate parity |
| odd_sel | input | 1 | 1 = odd parity, 0 = even parity |
| a_dat_o | output | 8 | A-side data pad output |
| a_par_o | output | 1 | A-side parity pad output |
| a_oe | output | 1 | A-side pad output enable |
| b_dat_o | output | 8 | B-side data pad output |
| b_par_o | output | 1 | B-side parity pad output |
| b_oe | output | 1 | B-side pad output enable |
| a_err_n | output | 1 | A-side parity error, active low |
| b_err_n | output | 1 | B-side parity error, active low |
| both_en_flag | output | 1 | Both output enables were requested together |

## Verification
Two functions can act in the same cycle:
- driving the outgoing word from the source stage;
- checking that word again in the destination stage through the loop-back path.

To provoke both at once, the bench enables both stages while one direction drives, under both modes, in both the transparent and the held state. It includes corrupted parity bits, so that pass mode must raise the destination error and generate mode must clear it. A reference model in the bench computes every output from the requirements and compares it in the middle of each cycle.

// File: rtl/ptx_pkg.sv
// Package: shared types for the latching parity transceiver.
// Assumes: nothing beyond standard SystemVerilog.
package ptx_pkg;

    // Direction decoded from the two active-low output enables.
    typedef enum logic [1:0] {
        DRV_NONE  = 2'b00,
        DRV_TO_B  = 2'b01,
        DRV_TO_A  = 2'b10,
        DRV_CLASH = 2'b11
    } ptx_dir_e;

endpackage

// File: rtl/ptx_side_latch.sv
// Module: one side's holding stage.
// Transparent while le=1. Holds the word captured at the last clock edge with le=1.
// Gives two views: one fed from the pad only (used as a source for driving),
// and one fed from the pad or the loop-back word (used for checking).
// Assumes: fb_sel=1 only while this side is driven, so its pad input is then unused.
module ptx_side_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         le,
    input  logic         odd_sel,
    input  logic [W-1:0] pad_d,
    input  logic         pad_p,
    input  logic         fb_sel,
    input  logic [W-1:0] fb_d,
    input  logic         fb_p,
    output logic [W-1:0] src_d,
    output logic         src_p,
    output logic [W-1:0] chk_d,
    output logic         chk_p,
    output logic         cap_o
);
    logic [W-1:0] held_d;
    logic         held_p;
    logic         held_cap;
    logic [W-1:0] in_d;
    logic         in_p;
    logic         held_view_p;

    // Select the stage input: the loop-back word while driven, else the pad.
    always_comb begin
        in_d = fb_sel ? fb_d : pad_d;
        in_p = fb_sel ? fb_p : pad_p;
    end

    // Before any capture, the held parity follows the sense, so zero data stays consistent.
    always_comb held_view_p = held_cap ? held_p : odd_sel;

    // Produce the transparent or held views.
    always_comb begin
        src_d = le ? pad_d : held_d;
        src_p = le ? pad_p : held_view_p;
        chk_d = le ? in_d  : held_d;
        chk_p = le ? in_p  : held_view_p;
        cap_o = le | held_cap;
    end

    // Capture the stage input on each edge while transparent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_d   <= '0;
            held_p   <= 1'b0;
            held_cap <= 1'b0;
        end else if (le) begin
            held_d   <= in_d;
            held_p   <= in_p;
            held_cap <= 1'b1;
        end
    end
endmodule

// File: rtl/ptx_dir_drive.sv
// Module: output stage for one direction.
// Drives the source word, with parity either generated or forwarded.
// Assumes: outputs read as zero when the direction is not enabled.
module ptx_dir_drive #(
    parameter int W = 8
) (
    input  logic         en,
    input  logic         fwd,
    input  logic         odd_sel,
    input  logic [W-1:0] src_d,
    input  logic         src_p,
    output logic [W-1:0] out_d,
    output logic         out_p
);
    logic gen_p;

    // Parity over the data bits in the selected sense.
    always_comb gen_p = (^src_d) ^ odd_sel;

    // Form the driven word, or zeros when idle.
    always_comb begin
        out_d = en ? src_d : '0;
        out_p = en ? (fwd ? src_p : gen_p) : 1'b0;
    end
endmodule

// File: rtl/ptx_par_check.sv
// Module: parity checker for one side's stage contents.
// Assumes: cap=0 means nothing has been seen since reset, so no error is reported.
module ptx_par_check #(
    parameter int W = 8
) (
    input  logic         cap,
    input  logic         odd_sel,
    input  logic [W-1:0] d,
    input  logic         p,
    output logic         err_n
);
    // Compare generated parity against the held or live parity bit.
    always_comb err_n = !cap || (((^d) ^ odd_sel) == p);
endmodule

// File: rtl/ptx_top.sv
// Module: latching parity transceiver between two 9-bit buses.
// Decodes direction, instantiates a holding stage, drive stage and checker per side,
// and feeds each driven word back into the destination stage.
// Assumes: pads are split into input, output and enable; reset is synchronous, active low.
module ptx_top #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] a_dat_i,
    input  logic          a_par_i,
    input  logic [DW-1:0] b_dat_i,
    input  logic          b_par_i,
    input  logic          lat_a_en,
    input  logic          lat_b_en,
    input  logic          drv_b_n,
    input  logic          drv_a_n,
    input  logic          fwd_mode,
    input  logic          odd_sel,
    output logic [DW-1:0] a_dat_o,
    output logic          a_par_o,
    output logic          a_oe,
    output logic [DW-1:0] b_dat_o,
    output logic          b_par_o,
    output logic          b_oe,
    output logic          a_err_n,
    output logic          b_err_n,
    output logic          both_en_flag
);
    import ptx_pkg::*;

    localparam int NSIDE = 2;

    ptx_dir_e     dir;
    logic         en_s   [NSIDE];
    logic [DW-1:0] pad_d [NSIDE];
    logic         pad_p  [NSIDE];
    logic         le_s   [NSIDE];
    logic [DW-1:0] src_d [NSIDE];
    logic         src_p  [NSIDE];
    logic [DW-1:0] chk_d [NSIDE];
    logic         chk_p  [NSIDE];
    logic         cap_s  [NSIDE];
    logic [DW-1:0] out_d [NSIDE];
    logic         out_p  [NSIDE];
    logic         err_s  [NSIDE];

    // Decode the active-low enables into a direction.
    always_comb begin
        unique case ({drv_a_n, drv_b_n})
            2'b10:   dir = DRV_TO_B;
            2'b01:   dir = DRV_TO_A;
            2'b00:   dir = DRV_CLASH;
            default: dir = DRV_NONE;
        endcase
    end

    // Per-side views of ports: index 0 is side A, index 1 is side B.
    always_comb begin
        en_s[0]  = (dir == DRV_TO_A);
        en_s[1]  = (dir == DRV_TO_B);
        pad_d[0] = a_dat_i;
        pad_d[1] = b_dat_i;
        pad_p[0] = a_par_i;
        pad_p[1] = b_par_i;
        le_s[0]  = lat_a_en;
        le_s[1]  = lat_b_en;
    end

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        // The stage on side s is looped back from the drive stage of side s.
        ptx_side_latch #(.W(DW)) u_lat (
            .clk    (clk),
            .rst_n  (rst_n),
            .le     (le_s[s]),
            .odd_sel(odd_sel),
            .pad_d  (pad_d[s]),
            .pad_p  (pad_p[s]),
            .fb_sel (en_s[s]),
            .fb_d   (out_d[s]),
            .fb_p   (out_p[s]),
            .src_d  (src_d[s]),
            .src_p  (src_p[s]),
            .chk_d  (chk_d[s]),
            .chk_p  (chk_p[s]),
            .cap_o  (cap_s[s])
        );

        // The drive stage for side s takes its word from the opposite stage.
        ptx_dir_drive #(.W(DW)) u_drv (
            .en     (en_s[s]),
            .fwd    (fwd_mode),
            .odd_sel(odd_sel),
            .src_d  (src_d[NSIDE-1-s]),
            .src_p  (src_p[NSIDE-1-s]),
            .out_d  (out_d[s]),
            .out_p  (out_p[s])
        );

        ptx_par_check #(.W(DW)) u_chk (
            .cap    (cap_s[s]),
            .odd_sel(odd_sel),
            .d      (chk_d[s]),
            .p      (chk_p[s]),
            .err_n  (err_s[s])
        );
    end

    // Map the per-side results back to ports.
    always_comb begin
        a_dat_o      = out_d[0];
        a_par_o      = out_p[0];
        a_oe         = en_s[0];
        b_dat_o      = out_d[1];
        b_par_o      = out_p[1];
        b_oe         = en_s[1];
        a_err_n      = err_s[0];
        b_err_n      = err_s[1];
        both_en_flag = (dir == DRV_CLASH);
    end
endmodule

// File: rtl/ptx_top_chk.sv
// Module: assertion checker bound to ptx_top.
// Assumes: it sees only the top-level ports.
module ptx_top_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-1:0] a_dat_i,
    input logic          a_par_i,
    input logic          lat_a_en,
    input logic          lat_b_en,
    input logic          drv_b_n,
    input logic          drv_a_n,
    input logic          fwd_mode,
    input logic          odd_sel,
    input logic [DW-1:0] a_dat_o,
    input logic          a_oe,
    input logic [DW-1:0] b_dat_o,
    input logic          b_par_o,
    input logic          b_oe,
    input logic          b_err_n,
    input logic          both_en_flag
);
    // R3
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_oe, b_oe}));

    // R4
    clash_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!drv_a_n && !drv_b_n) |-> (both_en_flag && !a_oe && !b_oe));

    // R6
    gen_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !fwd_mode) |-> (b_par_o == ((^b_dat_o) ^ odd_sel)));

    // R7
    pass_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && fwd_mode && lat_a_en) |-> (b_par_o == a_par_i && b_dat_o == a_dat_i));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !lat_a_en && $past(b_oe) && $past(!lat_a_en) && $past(rst_n))
            |-> (b_dat_o == $past(b_dat_o)));

    // R9
    loop_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !fwd_mode && lat_b_en) |-> b_err_n);

    // R11
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_oe |-> (a_dat_o == '0)) and (!b_oe |-> (b_dat_o == '0)));
endmodule

bind ptx_top ptx_top_chk #(.DW(DW)) u_ptx_top_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .a_dat_i     (a_dat_i),
    .a_par_i     (a_par_i),
    .lat_a_en    (lat_a_en),
    .lat_b_en    (lat_b_en),
    .drv_b_n     (drv_b_n),
    .drv_a_n     (drv_a_n),
    .fwd_mode    (fwd_mode),
    .odd_sel     (odd_sel),
    .a_dat_o     (a_dat_o),
    .a_oe        (a_oe),
    .b_dat_o     (b_dat_o),
    .b_par_o     (b_par_o),
    .b_oe        (b_oe),
    .b_err_n     (b_err_n),
    .both_en_flag(both_en_flag)
);

// File: tb/ptx_top_bench.sv
// Bench: directed corners plus seeded random steps, compared with a reference model.
module ptx_top_bench;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] a_dat_i = '0, b_dat_i = '0;
    logic          a_par_i = 1'b0, b_par_i = 1'b0;
    logic          lat_a_en = 1'b0, lat_b_en = 1'b0;
    logic          drv_b_n = 1'b1, drv_a_n = 1'b1;
    logic          fwd_mode = 1'b0, odd_sel = 1'b0;
    logic [DW-1:0] a_dat_o, b_dat_o;
    logic          a_par_o, a_oe, b_par_o, b_oe, a_err_n, b_err_n, both_en_flag;

    int checks = 0;
    int errors = 0;

    // Reference state for each side's holding stage.
    logic [DW-1:0] m_hd_a = '0, m_hd_b = '0;
    logic          m_hp_a = 1'b0, m_hp_b = 1'b0, m_cap_a = 1'b0, m_cap_b = 1'b0;

    // 200 MHz clock.
    always #2.5 clk = ~clk;

    ptx_top #(.DW(DW)) u_ptx_top (.*);

    // Generated parity in the selected sense (R5).
    function automatic logic gen_par(input logic [DW-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

    // Compare one value and report on mismatch.
    task automatic chk(input string tag, input string nm, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
        end
    endtask

    // Expected outputs for the present inputs, and the stage inputs to capture.
    logic [DW-1:0] e_ad, e_bd, e_ina_d, e_inb_d;
    logic e_ap, e_bp, e_aoe, e_boe, e_aerr, e_berr, e_clash, e_ina_p, e_inb_p;

    task automatic model();
        logic [DW-1:0] sa_d, sb_d, ca_d, cb_d;
        logic sa_p, sb_p, ca_p, cb_p;
        // R1, R2 and R10: source views.
        sa_d = lat_a_en ? a_dat_i : m_hd_a;
        sa_p = lat_a_en ? a_par_i : (m_cap_a ? m_hp_a : odd_sel);
        sb_d = lat_b_en ? b_dat_i : m_hd_b;
        sb_p = lat_b_en ? b_par_i : (m_cap_b ? m_hp_b : odd_sel);
        // R3 and R4: direction.
        e_boe   = !drv_b_n && drv_a_n;
        e_aoe   = !drv_a_n && drv_b_n;
        e_clash = !drv_a_n && !drv_b_n;
        // R6, R7 and R11: driven words.
        e_bd = e_boe ? sa_d : '0;
        e_bp = e_boe ? (fwd_mode ? sa_p : gen_par(sa_d, odd_sel)) : 1'b0;
        e_ad = e_aoe ? sb_d : '0;
        e_ap = e_aoe ? (fwd_mode ? sb_p : gen_par(sb_d, odd_sel)) : 1'b0;
        // R9: a driven side's stage sees the driven word.
        e_ina_d = e_aoe ? e_ad : a_dat_i;
        e_ina_p = e_aoe ? e_ap : a_par_i;
        e_inb_d = e_boe ? e_bd : b_dat_i;
        e_inb_p = e_boe ? e_bp : b_par_i;
        ca_d = lat_a_en ? e_ina_d : m_hd_a;
        ca_p = lat_a_en ? e_ina_p : (m_cap_a ? m_hp_a : odd_sel);
        cb_d = lat_b_en ? e_inb_d : m_hd_b;
        cb_p = lat_b_en ? e_inb_p : (m_cap_b ? m_hp_b : odd_sel);
        // R8 and R10: error flags.
        e_aerr = !(lat_a_en || m_cap_a) || (gen_par(ca_d, odd_sel) == ca_p);
        e_berr = !(lat_b_en || m_cap_b) || (gen_par(cb_d, odd_sel) == cb_p);
    endtask

    // Compare all outputs mid-cycle, then advance the model at the clock edge.
    task automatic step(input string tag);
        @(negedge clk);
        #1;
        model();
        chk(tag, "a_dat_o", {1'b0, a_dat_o}, {1'b0, e_ad});
        chk(tag, "a_par_o", {8'h0, a_par_o}, {8'h0, e_ap});
        chk(tag, "a_oe", {8'h0, a_oe}, {8'h0, e_aoe});
        chk(tag, "b_dat_o", {1'b0, b_dat_o}, {1'b0, e_bd});
        chk(tag, "b_par_o", {8'h0, b_par_o}, {8'h0, e_bp});
        chk(tag, "b_oe", {8'h0, b_oe}, {8'h0, e_boe});
        chk(tag, "a_err_n", {8'h0, a_err_n}, {8'h0, e_aerr});
        chk(tag, "b_err_n", {8'h0, b_err_n}, {8'h0, e_berr});
        chk(tag, "both_en_flag", {8'h0, both_en_flag}, {8'h0, e_clash});
        @(posedge clk);
        if (lat_a_en) begin m_hd_a = e_ina_d; m_hp_a = e_ina_p; m_cap_a = 1'b1; end
        if (lat_b_en) begin m_hd_b = e_inb_d; m_hp_b = e_inb_p; m_cap_b = 1'b1; end
        #0.5;
    endtask

    // Apply all control and data inputs at once.
    task automatic set(input logic la, lb, gb, ga, fw, od,
                       input logic [DW-1:0] ad, input logic ap,
                       input logic [DW-1:0] bd, input logic bp);
        lat_a_en = la; lat_b_en = lb; drv_b_n = gb; drv_a_n = ga;
        fwd_mode = fw; odd_sel = od;
        a_dat_i = ad; a_par_i = ap; b_dat_i = bd; b_par_i = bp;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10: nothing captured yet, so no error; held word is zero with parity equal to the sense.
        step("R10_reset_idle");
        set(0, 1, 0, 1, 1, 1, 8'hC3, 1'b0, 8'h00, 1'b0);
        step("R10_held_zero_fwd_odd");
        // R1, R5 and R6: transparent source, generated parity in both senses.
        set(1, 0, 0, 1, 0, 0, 8'h5A, 1'b1, 8'h00, 1'b0);
        step("R1_R6_even_gen");
        set(1, 0, 0, 1, 0, 1, 8'h5B, 1'b1, 8'h00, 1'b0);
        step("R5_odd_gen");
        // R7: pass mode forwards a wrong parity bit, and the loop-back check flags it.
        set(1, 1, 0, 1, 1, 1, 8'h5A, 1'b0, 8'h00, 1'b0);
        step("R7_R9_fwd_bad");
        set(1, 1, 0, 1, 0, 1, 8'h5A, 1'b0, 8'h00, 1'b0);
        step("R9_gen_clean_loop");
        // R2: hold, then change the pad.
        set(0, 0, 0, 1, 1, 1, 8'hFF, 1'b1, 8'h00, 1'b0);
        step("R2_hold_after_change");
        step("R2_hold_second");
        // R8: a bad word on A flags in both modes.
        set(1, 0, 1, 1, 0, 0, 8'h01, 1'b0, 8'h00, 1'b0);
        step("R8_err_gen_mode");
        set(1, 0, 1, 1, 1, 0, 8'h01, 1'b0, 8'h00, 1'b0);
        step("R8_err_fwd_mode");
        // R3: B to A, with the A-side loop-back check.
        set(1, 1, 1, 0, 1, 0, 8'h00, 1'b0, 8'h81, 1'b1);
        step("R3_R9_b_to_a");
        // R4 and R11: clash releases both sides.
        set(1, 1, 0, 0, 0, 0, 8'h3C, 1'b0, 8'h77, 1'b1);
        step("R4_R11_clash");
        set(0, 0, 1, 1, 0, 1, 8'h10, 1'b1, 8'h20, 1'b0);
        step("R3_R11_released");
        // Random mix of every combination.
        for (int i = 0; i < 400; i++) begin
            set($urandom_range(1), $urandom_range(1), $urandom_range(1), $urandom_range(1),
                $urandom_range(1), $urandom_range(1), 8'($urandom), 1'($urandom),
                8'($urandom), 1'($urandom));
            step("random_R1_R9");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule